// File: doc/BRIEF.md
# Filtered Transaction Event Qualifier

This block watches the stream of memory transactions accepted at a memory controller and decides, for each of a small set of filtered event counters, whether a transaction belongs to that counter's event. When it does, the block raises a one-cycle count-enable pulse for that counter in the cycle after the transaction was presented. It also keeps a per-counter byte tally, so the same filter can report transferred bytes instead of the number of bursts.

Each filtered counter has two programmable registers. The compare register holds a reference transaction ID and a stored ID mask. The stored mask has the opposite sense of the mask a user thinks in: a stored 1 means "ignore this ID bit". The selection register chooses read or write traffic, and can limit that traffic to one port through a port number and a qualifier enable. The registers and the byte tallies are reached through a simple write port and a combinational read port. The counters that consume the pulses are outside this block.

Top module: `axid_evt_filter`

## Requirements
- R1: After reset every count pulse is 0, every compare and selection register reads 0 and every byte tally reads 0.
- R2: For filtered counter k (k = 1..NCNT), the selection register sits at byte address 0x50 + 0x10*(k-1) and the compare register at 0x54 + 0x10*(k-1); a write takes effect at the clock edge and the full 32-bit value reads back at the same address. An address that maps to nothing reads 0. A transaction presented in the same cycle as a register write is judged with the old register value.
- R3: The compare register keeps the reference ID in bits 15:0 and the stored mask in bits 31:16. A transaction ID matches when every ID bit whose stored-mask bit is 0 equals the reference bit; ID bits whose stored-mask bit is 1 are ignored.
- R4: Selection bits 17:16 pick the event: 1 counts only read transactions (txn_write = 0), 2 counts only write transactions (txn_write = 1), 0 and 3 count nothing.
- R5: For read events, when selection bit 3 is 1 only transactions whose port equals selection bits 2:0 match; when bit 3 is 0 any port matches.
- R6: For write events, when selection bit 11 is 1 only transactions whose port equals selection bits 10:8 match; when bit 11 is 0 any port matches.
- R7: Each matching transaction (txn_valid = 1) gives cnt_pulse bit k-1 high for exactly the one cycle after the transaction cycle; cycles without a match give 0. Several counters may pulse in the same cycle.
- R8: At the same edge as the pulse, the counter's byte tally grows by txn_bytes; tally k reads at address 0x30 + 4*k, modulo 2^32.
- R9: Any write to a tally address clears that tally; if the counter matches a transaction in the same cycle, the clear wins and the tally reads 0, while the pulse still occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_write | input | 1 | 1 = write transaction, 0 = read |
| txn_id | input | 16 | Transaction ID |
| txn_port | input | 3 | Source port number |
| txn_bytes | input | BW | Bytes moved by the transaction |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte address |
| reg_rdata | output | 32 | Register read data (combinational) |
| cnt_pulse | output | NCNT | Count enables; bit k-1 serves filtered counter k |

## Verification
The filter is tried with exact-ID compares (full care mask), partial masks where only a nibble is compared, and an all-ignore mask, which separates the inverted stored-mask sense from a direct one. Read and write traffic is offered to counters set for each direction and for the disabled codes, with port qualifiers both on and off and with matching and non-matching ports, so a swapped direction or port field shows as a wrong pulse. Back-to-back and idle cycles check pulse timing against a queue of expected vectors, and tally reads after bursts of transactions, clears, and a clear colliding with a match check the byte path.

// File: rtl/axid_filt_pkg.sv
package axid_filt_pkg;

  localparam int ID_W   = 16;
  localparam int PORT_W = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int ACC_W  = 32;

  typedef enum logic [1:0] {
    KIND_OFF = 2'd0,
    KIND_RD  = 2'd1,
    KIND_WR  = 2'd2,
    KIND_RSV = 2'd3
  } evt_kind_e;

  // Register byte addresses for filtered counter index i (0-based, serves counter i+1)
  function automatic logic [ADDR_W-1:0] sel_addr(input int i);
    return 8'h50 + 8'(16 * i);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(input int i);
    return 8'h54 + 8'(16 * i);
  endfunction

  function automatic logic [ADDR_W-1:0] tally_addr(input int i);
    return 8'h34 + 8'(4 * i);
  endfunction

  // Stored mask bit 1 = ignore; care bits are its complement
  function automatic logic id_hit(input logic [DATA_W-1:0] cmp, input logic [ID_W-1:0] id);
    logic [ID_W-1:0] care;
    care = ~cmp[31:16];
    return ((id ^ cmp[15:0]) & care) == '0;
  endfunction

  function automatic logic port_hit(input logic en, input logic [PORT_W-1:0] want,
                                    input logic [PORT_W-1:0] port);
    return !en || (want == port);
  endfunction

  function automatic logic sel_hit(input logic [DATA_W-1:0] sel, input logic wr,
                                   input logic [PORT_W-1:0] port);
    evt_kind_e kind;
    kind = evt_kind_e'(sel[17:16]);
    case (kind)
      KIND_RD: return !wr && port_hit(sel[3], sel[2:0], port);
      KIND_WR: return  wr && port_hit(sel[11], sel[10:8], port);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/axid_filt_regs.sv
module axid_filt_regs
  import axid_filt_pkg::*;
#(
  parameter int NCNT = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [NCNT-1:0][DATA_W-1:0]  cmp_q,
  output logic [NCNT-1:0][DATA_W-1:0]  sel_q,
  output logic [NCNT-1:0]              tally_clr
);

  logic [NCNT-1:0] cmp_we;
  logic [NCNT-1:0] sel_we;

  always_comb begin
    for (int i = 0; i < NCNT; i++) begin
      cmp_we[i]    = reg_wr && (reg_addr == cmp_addr(i));
      sel_we[i]    = reg_wr && (reg_addr == sel_addr(i));
      tally_clr[i] = reg_wr && (reg_addr == tally_addr(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      sel_q <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (cmp_we[i]) cmp_q[i] <= reg_wdata;
        if (sel_we[i]) sel_q[i] <= reg_wdata;
      end
    end
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_chk
    assert_cmp_store_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr && (reg_addr == cmp_addr(g))) |-> cmp_q[g] == $past(reg_wdata));
    assert_sel_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_wr) |-> $stable(sel_q[g]));
  end

endmodule

// File: rtl/axid_filt_match.sv
module axid_filt_match
  import axid_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic              txn_write,
  input  logic [ID_W-1:0]   txn_id,
  input  logic [PORT_W-1:0] txn_port,
  input  logic [DATA_W-1:0] cmp,
  input  logic [DATA_W-1:0] sel,
  output logic              hit_now,
  output logic              hit_q
);

  logic id_ok;
  logic dir_ok;

  assign id_ok   = id_hit(cmp, txn_id);
  assign dir_ok  = sel_hit(sel, txn_write, txn_port);
  assign hit_now = txn_valid && id_ok && dir_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_now;
  end

  assert_pulse_needs_valid_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(txn_valid));
  assert_direction_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> ($past(txn_write) ? ($past(sel[17:16]) == 2'd2) : ($past(sel[17:16]) == 2'd1)));
  assert_rd_port_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !$past(txn_write) && $past(sel[3])) |-> ($past(txn_port) == $past(sel[2:0])));
  assert_wr_port_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(txn_write) && $past(sel[11])) |-> ($past(txn_port) == $past(sel[10:8])));

endmodule

// File: rtl/axid_filt_tally.sv
module axid_filt_tally
  import axid_filt_pkg::*;
#(
  parameter int BW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_now,
  input  logic [BW-1:0]    bytes,
  input  logic             clr,
  output logic [ACC_W-1:0] tally
);

  logic [ACC_W-1:0] sum_next;
  assign sum_next = tally + ACC_W'(bytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tally <= '0;
    else if (clr)     tally <= '0;
    else if (hit_now) tally <= sum_next;
  end

  assert_tally_add_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_now && !clr) |-> tally == $past(tally) + ACC_W'($past(bytes)));
  assert_tally_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> tally == '0);

endmodule

// File: rtl/axid_evt_filter.sv
module axid_evt_filter
  import axid_filt_pkg::*;
#(
  parameter int NCNT = 3,
  parameter int BW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic              txn_write,
  input  logic [15:0]       txn_id,
  input  logic [2:0]        txn_port,
  input  logic [BW-1:0]     txn_bytes,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [7:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic [NCNT-1:0]   cnt_pulse
);

  logic [NCNT-1:0][DATA_W-1:0] cmp_q;
  logic [NCNT-1:0][DATA_W-1:0] sel_q;
  logic [NCNT-1:0]             tally_clr;
  logic [NCNT-1:0]             hit_now;
  logic [ACC_W-1:0]            tally [NCNT];

  axid_filt_regs #(.NCNT(NCNT)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cmp_q     (cmp_q),
    .sel_q     (sel_q),
    .tally_clr (tally_clr)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    axid_filt_match match_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .txn_valid (txn_valid),
      .txn_write (txn_write),
      .txn_id    (txn_id),
      .txn_port  (txn_port),
      .cmp       (cmp_q[g]),
      .sel       (sel_q[g]),
      .hit_now   (hit_now[g]),
      .hit_q     (cnt_pulse[g])
    );

    axid_filt_tally #(.BW(BW)) tally_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_now (hit_now[g]),
      .bytes   (txn_bytes),
      .clr     (tally_clr[g]),
      .tally   (tally[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (reg_raddr == sel_addr(i))   reg_rdata = sel_q[i];
      if (reg_raddr == cmp_addr(i))   reg_rdata = cmp_q[i];
      if (reg_raddr == tally_addr(i)) reg_rdata = tally[i];
    end
  end

  assert_idle_no_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(txn_valid) |-> cnt_pulse == '0);

endmodule

// File: tb/axid_evt_filter_tb.sv
module axid_evt_filter_tb_top;

  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0;
  logic        txn_write = 1'b0;
  logic [15:0] txn_id = '0;
  logic [2:0]  txn_port = '0;
  logic [15:0] txn_bytes = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] cnt_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  bit [31:0] m_cmp [NC];
  bit [31:0] m_sel [NC];
  bit [31:0] m_acc [NC];

  int       due_q [$];
  bit [2:0] exp_q [$];
  string    tag_q [$];

  always #10 clk = ~clk;

  axid_evt_filter dut_i (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_write(txn_write),
    .txn_id(txn_id), .txn_port(txn_port), .txn_bytes(txn_bytes),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .cnt_pulse(cnt_pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input bit [31:0] act, input bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Bench-side decision: walk the ID bits one by one
  function automatic bit model_hit(int i, bit w, bit [15:0] id, bit [2:0] p);
    bit [1:0] kind = m_sel[i][17:16];
    if (kind == 2'd1) begin
      if (w) return 0;
      if (m_sel[i][3] && (m_sel[i][2:0] != p)) return 0;
    end else if (kind == 2'd2) begin
      if (!w) return 0;
      if (m_sel[i][11] && (m_sel[i][10:8] != p)) return 0;
    end else return 0;
    for (int b = 0; b < 16; b++)
      if (!m_cmp[i][16+b] && (id[b] != m_cmp[i][b])) return 0;
    return 1;
  endfunction

  // Driver: one cycle of stimulus, pushes the expected pulse vector
  task automatic tick(input bit v, input bit w, input bit [15:0] id, input bit [2:0] p,
                      input bit [15:0] by, input bit rw, input bit [7:0] ra,
                      input bit [31:0] rd, input string tag);
    bit [2:0] e = '0;
    @(negedge clk);
    txn_valid = v; txn_write = w; txn_id = id; txn_port = p; txn_bytes = by;
    reg_wr = rw; reg_addr = ra; reg_wdata = rd;
    for (int i = 0; i < NC; i++) begin
      e[i] = v && model_hit(i, w, id, p);
      if (e[i]) m_acc[i] += 32'(by);
    end
    due_q.push_back(cyc + 1);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (rw) begin
      for (int i = 0; i < NC; i++) begin
        if (ra == 8'h50 + 8'(16*i)) m_sel[i] = rd;
        if (ra == 8'h54 + 8'(16*i)) m_cmp[i] = rd;
        if (ra == 8'h34 + 8'(4*i))  m_acc[i] = 0;
      end
    end
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 0, 0, 0, "R7");
  endtask

  task automatic wreg(input bit [7:0] a, input bit [31:0] d);
    tick(0, 0, 0, 0, 0, 1, a, d, "R2");
  endtask

  task automatic tx(input bit w, input bit [15:0] id, input bit [2:0] p,
                    input bit [15:0] by, input string tag);
    tick(1, w, id, p, by, 0, 0, 0, tag);
  endtask

  task automatic rd_chk(input string req, input bit [7:0] a, input bit [31:0] exp);
    idle();
    reg_raddr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // Monitor: pops expected vectors as the design produces them
  always @(negedge clk) begin
    if (rst_n && due_q.size() > 0 && due_q[0] == cyc) begin
      void'(due_q.pop_front());
      chk({tag_q.pop_front(), " pulse"}, 32'(cnt_pulse), 32'(exp_q.pop_front()));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_cmp[i] = 0; m_sel[i] = 0; m_acc[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pulse in reset", 32'(cnt_pulse), 0);
    rst_n = 1'b1;
    // R1: reset values of all registers and tallies
    for (int i = 0; i < NC; i++) begin
      rd_chk("R1 sel", 8'h50 + 8'(16*i), 0);
      rd_chk("R1 cmp", 8'h54 + 8'(16*i), 0);
      rd_chk("R1 tally", 8'h34 + 8'(4*i), 0);
    end
    // R2: program and read back
    wreg(8'h54, 32'h0000_1234);          // counter 1: exact ID 0x1234
    wreg(8'h50, 32'h0001_0000);          // counter 1: reads, any port
    wreg(8'h64, 32'hFF0F_00A0);          // counter 2: compare ID bits 7:4 only
    wreg(8'h60, 32'h0002_0D00);          // counter 2: writes, port 5 only
    wreg(8'h74, 32'hFFFF_0000);          // counter 3: ignore whole ID
    wreg(8'h70, 32'h0001_000A);          // counter 3: reads, port 2 only
    rd_chk("R2 cmp1", 8'h54, 32'h0000_1234);
    rd_chk("R2 sel2", 8'h60, 32'h0002_0D00);
    rd_chk("R2 cmp3", 8'h74, 32'hFFFF_0000);
    rd_chk("R2 unmapped", 8'h58, 0);
    rd_chk("R2 unmapped", 8'h30, 0);
    // R3/R4/R5: exact ID read, port 3 so counter 3 stays out
    tx(0, 16'h1234, 3'd3, 16'd64, "R3");
    tx(0, 16'h1235, 3'd3, 16'd64, "R3");
    tx(1, 16'h1234, 3'd3, 16'd32, "R4");
    // R5: port-qualified read hits counter 3 (and counter 1 when ID matches)
    tx(0, 16'h1234, 3'd2, 16'd16, "R5");
    tx(0, 16'hBEEF, 3'd2, 16'd8,  "R5");
    tx(0, 16'hBEEF, 3'd6, 16'd8,  "R5");
    // R6: write port qualifier and partial mask on counter 2
    tx(1, 16'h12A7, 3'd5, 16'd128, "R6");
    tx(1, 16'h12A7, 3'd4, 16'd128, "R6");
    tx(1, 16'h55AF, 3'd5, 16'd4,   "R3");
    tx(1, 16'h12B7, 3'd5, 16'd4,   "R3");
    tx(0, 16'h12A7, 3'd5, 16'd4,   "R4");
    // R7: back-to-back matches, then idle
    tx(0, 16'h1234, 3'd2, 16'd1, "R7");
    tx(0, 16'h1234, 3'd2, 16'd2, "R7");
    idle();
    tx(0, 16'h1234, 3'd2, 16'd3, "R7");
    // R8: tallies
    rd_chk("R8 tally1", 8'h34, m_acc[0]);
    rd_chk("R8 tally2", 8'h38, m_acc[1]);
    rd_chk("R8 tally3", 8'h3C, m_acc[2]);
    // R2: write to register in the same cycle as a transaction uses the old value
    tick(1, 0, 16'h1234, 3'd1, 16'd10, 1, 8'h50, 32'h0003_0000, "R2");
    tx(0, 16'h1234, 3'd1, 16'd10, "R4");
    wreg(8'h50, 32'h0000_0000);
    tx(0, 16'h1234, 3'd1, 16'd10, "R4");
    rd_chk("R4 tally1", 8'h34, m_acc[0]);
    // R6: port qualifier off for writes
    wreg(8'h60, 32'h0002_0500);
    tx(1, 16'h00A0, 3'd1, 16'd7, "R6");
    rd_chk("R8 tally2", 8'h38, m_acc[1]);
    // R9: clear, then clear colliding with a match
    wreg(8'h38, 32'hDEAD_BEEF);
    rd_chk("R9 tally2 cleared", 8'h38, 0);
    tick(1, 0, 16'h0000, 3'd2, 16'd99, 1, 8'h3C, 0, "R9");
    rd_chk("R9 tally3 clear wins", 8'h3C, 0);
    tx(0, 16'h0000, 3'd2, 16'd5, "R8");
    rd_chk("R8 tally3 after clear", 8'h3C, 32'd5);
    repeat (3) idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule